// File: doc/BRIEF.md
# Packet Buffer RAM Pattern Self-Test Engine

This block exercises a word-organised packet buffer RAM through a synchronous single-port master port and reports whether every word held the values written to it. The RAM is addressed in bytes and accessed as 16-bit words, so the address moves by two on every access. One start pulse runs four passes. Each pass first fills the whole RAM with one background and then reads every word back and compares it against the value that was written.

The four backgrounds come in a fixed order. The first is each word's own byte address. The second is that address with all bits inverted inside the RAM's byte range. The third and fourth are two complementary checkerboard constants. A single fault counter adds one for each word that reads back wrong and is not cleared between passes. When the run ends, the engine raises a done flag and a pass flag, and the count stays visible until the next start.

Top module: `ram_pattern_bist`

## Requirements
- R1: While reset is asserted and after it is released, done_o, pass_o and ram_we_o are 0 and fault_cnt_o is 0.
- R2: Every RAM address driven is even. Within a pass, the writes go to byte addresses 0, 2, 4, ... up to RAM_BYTES-2, one word per cycle, in ascending order.
- R3: The written value is, in order: pass 1 the 16-bit byte address; pass 2 the byte address XOR (RAM_BYTES-1); pass 3 16'hAA55; pass 4 16'h55AA. After a run, every word holds 16'h55AA.
- R4: In each pass, all RAM_BYTES/2 writes happen in one unbroken run before any read of that pass. Reads never fall between the writes.
- R5: Read data is compared one cycle after the read address is presented. Each word that mismatches adds exactly one to fault_cnt_o. The count accumulates over all four passes and is cleared only when a start is accepted.
- R6: fault_cnt_o saturates at 2^FCNT_W-1 and does not wrap.
- R7: done_o rises exactly 4*(3*RAM_BYTES/2+1) clock cycles after the edge that samples start_i. pass_o is 1 with done_o only when fault_cnt_o is 0. ram_we_o is 0 when the engine is idle or done.
- R8: A start_i pulse during a run is ignored. The run length and the final fault count are unchanged.
- R9: done_o and fault_cnt_o hold their values until start_i is sampled. A start sampled while idle or done clears the count and lowers done_o from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse; accepted only while idle or done |
| done_o | output | 1 | Run complete, held until the next accepted start |
| pass_o | output | 1 | Run complete with zero faults |
| fault_cnt_o | output | FCNT_W | Saturating count of mismatching words |
| ram_addr_o | output | ADDR_W | RAM byte address, always even |
| ram_wdata_o | output | 16 | RAM write data |
| ram_we_o | output | 1 | RAM write enable |
| ram_rdata_i | input | 16 | RAM read data, valid one cycle after the address |

## Verification
The bench builds the engine with RAM_BYTES = 64 and FCNT_W = 4. The 32-word RAM keeps a full four-pass run to a few hundred cycles, so the exact run length can be checked for every scenario. The 4-bit counter lets a stuck bit across all words drive the count past 15 and show saturation. The bench's own RAM model injects stuck-at bits on a single word or on all words. It predicts from the four backgrounds in which passes a fault shows up, which exercises both the address-derived patterns and accumulation across passes.

// File: rtl/rpb_pkg.sv
package rpb_pkg;

    localparam int unsigned WORD_W = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WRITE,
        ST_READ,
        ST_CHECK,
        ST_NEXT_PASS,
        ST_DONE
    } rpb_state_e;

    localparam logic [WORD_W-1:0] BG_CHECKER_A = 16'hAA55;
    localparam logic [WORD_W-1:0] BG_CHECKER_B = 16'h55AA;

endpackage

// File: rtl/rpb_pattern_gen.sv
module rpb_pattern_gen #(
    parameter int unsigned RAM_BYTES = 65536,
    parameter int unsigned ADDR_W    = $clog2(RAM_BYTES)
) (
    input  logic [1:0]                  pass_i,
    input  logic [ADDR_W-1:0]           addr_i,
    output logic [rpb_pkg::WORD_W-1:0]  word_o
);
    import rpb_pkg::*;

    localparam logic [WORD_W-1:0] SPAN_MASK = WORD_W'(RAM_BYTES - 1);

    logic [WORD_W-1:0] addr_word;

    generate
        if (ADDR_W >= WORD_W) begin : g_wide
            assign addr_word = addr_i[WORD_W-1:0];
        end else begin : g_narrow
            assign addr_word = {{(WORD_W-ADDR_W){1'b0}}, addr_i};
        end
    endgenerate

    always_comb begin
        unique case (pass_i)
            2'd0:    word_o = addr_word;
            2'd1:    word_o = addr_word ^ SPAN_MASK;
            2'd2:    word_o = BG_CHECKER_A;
            default: word_o = BG_CHECKER_B;
        endcase
    end

endmodule

// File: rtl/rpb_fault_counter.sv
module rpb_fault_counter #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             hit_i,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (hit_i && (cnt_q != CNT_MAX)) begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/ram_pattern_bist.sv
module ram_pattern_bist #(
    parameter int unsigned RAM_BYTES = 65536,
    parameter int unsigned FCNT_W    = 16,
    parameter int unsigned ADDR_W    = $clog2(RAM_BYTES)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start_i,
    output logic                         done_o,
    output logic                         pass_o,
    output logic [FCNT_W-1:0]            fault_cnt_o,
    output logic [ADDR_W-1:0]            ram_addr_o,
    output logic [rpb_pkg::WORD_W-1:0]   ram_wdata_o,
    output logic                         ram_we_o,
    input  logic [rpb_pkg::WORD_W-1:0]   ram_rdata_i
);
    import rpb_pkg::*;

    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(RAM_BYTES - 2);
    localparam logic [ADDR_W-1:0] ADDR_STEP = ADDR_W'(2);
    localparam logic [1:0]        LAST_PASS = 2'd3;

    typedef struct packed {
        rpb_state_e        state;
        logic [1:0]        pass;
        logic [ADDR_W-1:0] addr;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    rpb_state_e state_q;
    logic start_acc;
    logic mismatch_hit;
    logic [WORD_W-1:0] expected;

    assign state_q = ctl_q.state;

    rpb_pattern_gen #(
        .RAM_BYTES (RAM_BYTES),
        .ADDR_W    (ADDR_W)
    ) i_pattern (
        .pass_i (ctl_q.pass),
        .addr_i (ctl_q.addr),
        .word_o (expected)
    );

    rpb_fault_counter #(
        .CNT_W (FCNT_W)
    ) i_faults (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (start_acc),
        .hit_i (mismatch_hit),
        .cnt_o (fault_cnt_o)
    );

    always_comb begin
        ctl_d        = ctl_q;
        start_acc    = 1'b0;
        mismatch_hit = 1'b0;
        unique case (ctl_q.state)
            ST_IDLE, ST_DONE: begin
                if (start_i) begin
                    start_acc   = 1'b1;
                    ctl_d.state = ST_WRITE;
                    ctl_d.pass  = '0;
                    ctl_d.addr  = '0;
                end
            end
            ST_WRITE: begin
                if (ctl_q.addr == LAST_ADDR) begin
                    ctl_d.addr  = '0;
                    ctl_d.state = ST_READ;
                end else begin
                    ctl_d.addr = ctl_q.addr + ADDR_STEP;
                end
            end
            ST_READ: begin
                ctl_d.state = ST_CHECK;
            end
            ST_CHECK: begin
                mismatch_hit = (ram_rdata_i != expected);
                if (ctl_q.addr == LAST_ADDR) begin
                    ctl_d.state = ST_NEXT_PASS;
                end else begin
                    ctl_d.addr  = ctl_q.addr + ADDR_STEP;
                    ctl_d.state = ST_READ;
                end
            end
            ST_NEXT_PASS: begin
                ctl_d.addr = '0;
                if (ctl_q.pass == LAST_PASS) begin
                    ctl_d.state = ST_DONE;
                end else begin
                    ctl_d.pass  = ctl_q.pass + 2'd1;
                    ctl_d.state = ST_WRITE;
                end
            end
            default: begin
                ctl_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{state: ST_IDLE, pass: 2'd0, addr: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign ram_addr_o  = ctl_q.addr;
    assign ram_wdata_o = expected;
    assign ram_we_o    = (state_q == ST_WRITE);
    assign done_o      = (state_q == ST_DONE);
    assign pass_o      = done_o && (fault_cnt_o == '0);

endmodule

// File: rtl/ram_pattern_bist_chk.sv
module ram_pattern_bist_chk #(
    parameter int unsigned FCNT_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start_i,
    input logic               done_o,
    input logic               ram_we_o,
    input logic               addr_lsb,
    input logic [FCNT_W-1:0]  fault_cnt_o,
    input rpb_pkg::rpb_state_e state_q
);
    import rpb_pkg::*;

    logic busy;
    logic reading_q;

    assign busy = (state_q != ST_IDLE) && (state_q != ST_DONE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reading_q <= 1'b0;
        end else if (state_q == ST_READ) begin
            reading_q <= 1'b1;
        end else if (state_q == ST_NEXT_PASS || !busy) begin
            reading_q <= 1'b0;
        end
    end

    // R2
    addr_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_lsb == 1'b0);

    // R4
    no_write_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reading_q |-> !ram_we_o);

    // R5
    fault_cnt_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_i && !busy) |=> fault_cnt_o >= $past(fault_cnt_o));

    // R7
    write_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we_o |-> busy);

    // R8
    busy_start_no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start_i && state_q != ST_NEXT_PASS) |=> state_q != ST_WRITE || $past(state_q) == ST_WRITE);

    // R9
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> (done_o && $stable(fault_cnt_o)));

endmodule

bind ram_pattern_bist ram_pattern_bist_chk #(
    .FCNT_W (FCNT_W)
) i_ram_pattern_bist_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .done_o      (done_o),
    .ram_we_o    (ram_we_o),
    .addr_lsb    (ram_addr_o[0]),
    .fault_cnt_o (fault_cnt_o),
    .state_q     (state_q)
);

// File: tb/test_ram_pattern_bist.sv
`timescale 1ns/1ps
module test_ram_pattern_bist;
    localparam int RB    = 64;
    localparam int FW    = 4;
    localparam int AW    = $clog2(RB);
    localparam int WORDS = RB / 2;
    localparam int RUN_CYC = 4 * (3 * WORDS + 1) + 1;
    localparam int SAT   = (1 << FW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic done_o, pass_o, ram_we_o;
    logic [FW-1:0] fault_cnt_o;
    logic [AW-1:0] ram_addr_o;
    logic [15:0] ram_wdata_o;
    logic [15:0] ram_rdata_i = '0;

    always #2.5 clk = ~clk;

    ram_pattern_bist #(.RAM_BYTES(RB), .FCNT_W(FW)) i_ram_pattern_bist (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .done_o(done_o),
        .pass_o(pass_o), .fault_cnt_o(fault_cnt_o), .ram_addr_o(ram_addr_o),
        .ram_wdata_o(ram_wdata_o), .ram_we_o(ram_we_o), .ram_rdata_i(ram_rdata_i)
    );

    int tests = 0;
    int fails = 0;

    // RAM model with stuck-at fault injection on reads
    logic [15:0] mem [WORDS];
    bit flt_en = 0;
    bit flt_all = 0;
    int flt_word = 0;
    logic [15:0] flt_or = '0;
    logic [15:0] flt_and = '0;

    function automatic logic [15:0] corrupt(input logic [15:0] v, input int idx);
        if (flt_en && (flt_all || idx == flt_word))
            return (v & ~flt_and) | flt_or;
        return v;
    endfunction

    function automatic logic [15:0] bg(input int p, input int a);
        case (p)
            0: return 16'(a);
            1: return 16'(a ^ (RB - 1));
            2: return 16'hAA55;
            default: return 16'h55AA;
        endcase
    endfunction

    function automatic int predict_faults();
        int n = 0;
        for (int p = 0; p < 4; p++)
            for (int w = 0; w < WORDS; w++)
                if (corrupt(bg(p, 2 * w), w) != bg(p, 2 * w)) n++;
        return (n > SAT) ? SAT : n;
    endfunction

    always @(posedge clk) begin
        if (ram_we_o) mem[int'(ram_addr_o >> 1)] <= ram_wdata_o;
        ram_rdata_i <= corrupt(mem[int'(ram_addr_o >> 1)], int'(ram_addr_o >> 1));
    end

    // write-stream monitor, sampled at negedge
    int mon_wr = 0, mon_bad = 0, mon_runs = 0, mon_runbad = 0, run_len = 0;
    bit prev_we = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (ram_we_o) begin
                if (int'(ram_addr_o) != 2 * (mon_wr % WORDS) ||
                    ram_wdata_o != bg(mon_wr / WORDS, 2 * (mon_wr % WORDS)))
                    mon_bad++;
                mon_wr++;
                run_len++;
            end else begin
                if (ram_addr_o[0]) mon_bad++;
                if (prev_we) begin
                    mon_runs++;
                    if (run_len != WORDS) mon_runbad++;
                    run_len = 0;
                end
            end
            prev_we = ram_we_o;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_bist(input int busy_at, output int n);
        @(negedge clk);
        mon_wr = 0; mon_bad = 0; mon_runs = 0; mon_runbad = 0; run_len = 0;
        start_i = 1'b1;
        n = 0;
        do begin
            @(negedge clk);
            n++;
            start_i = (n == busy_at);
        end while (!done_o && n < 5000);
        start_i = 1'b0;
    endtask

    task automatic t_reset();
        chk(done_o == 0 && pass_o == 0 && ram_we_o == 0, "R1 outputs in reset", done_o, 0);
        chk(fault_cnt_o == 0, "R1 count in reset", int'(fault_cnt_o), 0);
        @(negedge clk); rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(done_o == 0 && ram_we_o == 0 && fault_cnt_o == 0, "R1 idle after reset", done_o, 0);
    endtask

    task automatic t_clean();
        int n, bad;
        flt_en = 0;
        run_bist(0, n);
        chk(n == RUN_CYC, "R7 run length", n, RUN_CYC);
        chk(pass_o == 1, "R7 pass on clean RAM", pass_o, 1);
        chk(fault_cnt_o == 0, "R5 no faults on clean RAM", int'(fault_cnt_o), 0);
        chk(mon_wr == 4 * WORDS, "R2 write count", mon_wr, 4 * WORDS);
        chk(mon_bad == 0, "R3 write address/data order", mon_bad, 0);
        chk(mon_runs == 4 && mon_runbad == 0, "R4 writes contiguous per pass", mon_runbad, 0);
        bad = 0;
        for (int w = 0; w < WORDS; w++) if (mem[w] != 16'h55AA) bad++;
        chk(bad == 0, "R3 final contents 55AA", bad, 0);
    endtask

    task automatic t_single_fault();
        int n, e;
        flt_en = 1; flt_all = 0; flt_word = 5; flt_or = 16'h0008; flt_and = 16'h0000;
        e = predict_faults();
        run_bist(0, n);
        chk(int'(fault_cnt_o) == e, "R5 single stuck bit accumulates", int'(fault_cnt_o), e);
        chk(e == 2, "R3 address-xor pattern exposes bit", e, 2);
        chk(pass_o == 0 && done_o == 1, "R7 pass low with faults", pass_o, 0);
    endtask

    task automatic t_saturate();
        int n, e;
        flt_en = 1; flt_all = 1; flt_or = 16'h0000; flt_and = 16'h0001;
        e = predict_faults();
        run_bist(0, n);
        chk(int'(fault_cnt_o) == SAT && e == SAT, "R6 saturation", int'(fault_cnt_o), SAT);
        chk(n == RUN_CYC, "R7 run length with faults", n, RUN_CYC);
    endtask

    task automatic t_busy_start();
        int n, e;
        flt_en = 1; flt_all = 0; flt_word = 5; flt_or = 16'h0008; flt_and = 16'h0000;
        e = predict_faults();
        run_bist(250, n);
        chk(n == RUN_CYC, "R8 busy start ignored (length)", n, RUN_CYC);
        chk(int'(fault_cnt_o) == e, "R8 busy start keeps count", int'(fault_cnt_o), e);
    endtask

    task automatic t_hold_restart();
        int n;
        logic [FW-1:0] held;
        held = fault_cnt_o;
        repeat (20) @(negedge clk);
        chk(done_o == 1 && fault_cnt_o == held, "R9 done and count held", int'(fault_cnt_o), int'(held));
        flt_en = 0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(done_o == 0 && fault_cnt_o == 0, "R9 restart clears", int'(fault_cnt_o), 0);
        n = 0;
        while (!done_o && n < 5000) begin @(negedge clk); n++; end
        chk(pass_o == 1 && fault_cnt_o == 0, "R9 rerun passes", int'(fault_cnt_o), 0);
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_clean();
        t_single_fault();
        t_saturate();
        t_busy_start();
        t_hold_restart();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule